// File: doc/BRIEF.md
# Exception Cause Priority Selector

This block reduces the set of exception flags raised by one instruction to a single cause. The 16-bit input vector is indexed by cause number. The block first masks the vector according to a mode input. It then picks the surviving flag that comes first in a fixed priority order, which is not the numeric order of the causes. The result is registered, together with the masked vector, so that later stages can still see every cause that remained after masking.

The selector has four masking modes:

- pass every implemented cause;
- keep only the causes a fetch stage can raise;
- apply a caller-supplied enable mask;
- apply both the fetch filter and the enable mask.

An execution unit can therefore drop causes it cannot produce before selection takes place.

Top module: `exc_cause_sel`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `out_valid`=0, `out_hit`=0, `out_cause`=0 and `out_flags`=0.
- R2: The outputs take the result for the inputs sampled at the same edge, so there is one cycle of latency. An edge with `in_valid`=1 gives `out_valid`=1. An edge with `in_valid`=0 gives `out_valid`=0 with `out_hit`, `out_cause` and `out_flags` all zero.
- R3: Input bits 10 and 14 are never implemented and are ignored in every mode. They appear as 0 in `out_flags` and never set `out_hit`.
- R4: When `in_mode`=2'b00, every implemented cause bit (0–9, 11–13, 15) passes into the masked vector.
- R5: When `in_mode`=2'b01, only cause bits 0, 1, 2 and 12 pass. All other bits are forced to 0.
- R6: When `in_mode`=2'b10, bit i passes only when `in_unit_mask[i]`=1.
- R7: When `in_mode`=2'b11, bit i passes only when it is one of 0, 1, 2, 12 and `in_unit_mask[i]`=1.
- R8: `out_cause` is the cause number of the masked flag that ranks highest. The ranking from highest to lowest is 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5.
- R9: When `in_valid`=1 and no flag survives masking, `out_valid`=1, `out_hit`=0 and `out_cause`=0.
- R10: `out_flags` equals the masked vector, and `out_hit` is 1 exactly when `out_flags` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_mode | input | 2 | Masking mode (see R4–R7) |
| in_flags | input | 16 | Raised exception flags, bit index = cause number |
| in_unit_mask | input | 16 | Per-unit enable mask for modes 2'b10 and 2'b11 |
| out_valid | output | 1 | Registered result valid |
| out_hit | output | 1 | At least one cause survived masking |
| out_cause | output | 4 | Highest-ranked surviving cause number, 0 when none |
| out_flags | output | 16 | Registered masked flag vector |

## Verification
Pairs of flags that sit next to each other in the ranking, one pair per rank, show that the order is the listed one and not lowest-index-wins. The all-ones vector is tried in every mode, which separates the masking modes from one another. Vectors made only of bits 10 and 14, or only of non-fetch causes in the fetch mode, show that an empty result gives `out_hit`=0 with cause 0. Random vectors, modes and masks, interleaved with idle cycles, cover the remaining combinations and the one-cycle latency.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

  localparam int unsigned NCAUSE = 16;
  localparam int unsigned CW     = $clog2(NCAUSE);
  localparam int unsigned NRANK  = 14;

  // Implemented cause bits: everything except 10 and 14.
  localparam logic [NCAUSE-1:0] IMPL_MASK  = 16'hBBFF;
  // Causes a fetch stage can raise: 0, 1, 2, 12.
  localparam logic [NCAUSE-1:0] FETCH_MASK = 16'h1007;

  typedef enum logic [1:0] {
    SEL_ALL        = 2'b00,
    SEL_FETCH      = 2'b01,
    SEL_UNIT       = 2'b10,
    SEL_FETCH_UNIT = 2'b11
  } sel_mode_e;

  // Cause number held at a given rank (rank 0 wins).
  function automatic logic [CW-1:0] rank_cause(input int r);
    logic [CW-1:0] c;
    case (r)
      0:  c = 4'd3;
      1:  c = 4'd12;
      2:  c = 4'd1;
      3:  c = 4'd2;
      4:  c = 4'd0;
      5:  c = 4'd11;
      6:  c = 4'd9;
      7:  c = 4'd8;
      8:  c = 4'd6;
      9:  c = 4'd4;
      10: c = 4'd15;
      11: c = 4'd13;
      12: c = 4'd7;
      default: c = 4'd5;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/exc_mask_stage.sv
module exc_mask_stage
  import exc_sel_pkg::*;
#(
  parameter int unsigned N = NCAUSE
) (
  input  logic [N-1:0] flags,
  input  logic [1:0]   mode,
  input  logic [N-1:0] unit_mask,
  output logic [N-1:0] masked
);

  logic [N-1:0] fetch_gate;
  logic [N-1:0] unit_gate;

  always_comb begin
    fetch_gate = mode[0] ? FETCH_MASK : {N{1'b1}};
    unit_gate  = mode[1] ? unit_mask  : {N{1'b1}};
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign masked[i] = flags[i] & IMPL_MASK[i] & fetch_gate[i] & unit_gate[i];
  end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_sel_pkg::*;
#(
  parameter int unsigned N     = NCAUSE,
  parameter int unsigned RANKS = NRANK,
  localparam int unsigned W    = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         hit,
  output logic [W-1:0] cause
);

  logic [RANKS:0]   seen;
  logic [RANKS-1:0] take;
  logic [W-1:0]     part [RANKS+1];

  assign seen[0] = 1'b0;
  assign part[0] = '0;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    localparam logic [W-1:0] C = rank_cause(r);
    assign take[r]     = vec[C] & ~seen[r];
    assign seen[r+1]   = seen[r] | vec[C];
    assign part[r+1]   = part[r] | (take[r] ? C : '0);
  end

  assign hit   = |vec;
  assign cause = part[RANKS];

endmodule

// File: rtl/exc_out_reg.sv
module exc_out_reg #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic         d_hit,
  input  logic [W-1:0] d_cause,
  input  logic [N-1:0] d_flags,
  output logic         q_valid,
  output logic         q_hit,
  output logic [W-1:0] q_cause,
  output logic [N-1:0] q_flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_hit   <= 1'b0;
      q_cause <= '0;
      q_flags <= '0;
    end else begin
      q_valid <= d_valid;
      q_hit   <= d_valid & d_hit;
      q_cause <= d_valid ? d_cause : '0;
      q_flags <= d_valid ? d_flags : '0;
    end
  end

endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_sel_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    in_mode,
  input  logic [15:0]   in_flags,
  input  logic [15:0]   in_unit_mask,
  output logic          out_valid,
  output logic          out_hit,
  output logic [3:0]    out_cause,
  output logic [15:0]   out_flags
);

  logic [NCAUSE-1:0] masked;
  logic              pick_hit;
  logic [CW-1:0]     pick_cause;

  exc_mask_stage #(.N(NCAUSE)) u_mask (
    .flags     (in_flags),
    .mode      (in_mode),
    .unit_mask (in_unit_mask),
    .masked    (masked)
  );

  exc_prio_pick #(.N(NCAUSE), .RANKS(NRANK)) u_pick (
    .vec   (masked),
    .hit   (pick_hit),
    .cause (pick_cause)
  );

  exc_out_reg #(.N(NCAUSE), .W(CW)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_hit   (pick_hit),
    .d_cause (pick_cause),
    .d_flags (masked),
    .q_valid (out_valid),
    .q_hit   (out_hit),
    .q_cause (out_cause),
    .q_flags (out_flags)
  );

endmodule

// File: rtl/exc_cause_sel_chk.sv
module exc_cause_sel_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [1:0]  in_mode,
  input logic [15:0] in_unit_mask,
  input logic        out_valid,
  input logic        out_hit,
  input logic [3:0]  out_cause,
  input logic [15:0] out_flags
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && !out_hit && out_flags == 16'h0)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && out_flags == 16'h0 && out_cause == 4'h0)); // R2
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst) (out_flags[10] == 1'b0 && out_flags[14] == 1'b0)); // R3
  AST_FETCH_ONLY: assert property (@(posedge clk) disable iff (rst) (in_valid && in_mode[0]) |=> ((out_flags & ~16'h1007) == 16'h0)); // R5
  AST_UNIT_GATE: assert property (@(posedge clk) disable iff (rst) (in_valid && in_mode[1]) |=> ((out_flags & ~$past(in_unit_mask)) == 16'h0)); // R6
  AST_CAUSE_PRESENT: assert property (@(posedge clk) disable iff (rst) out_hit |-> out_flags[out_cause]); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst) !out_hit |-> (out_cause == 4'h0)); // R9
  AST_HIT_MATCHES: assert property (@(posedge clk) disable iff (rst) out_hit == (out_flags != 16'h0)); // R10

endmodule

bind exc_cause_sel exc_cause_sel_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_mode      (in_mode),
  .in_unit_mask (in_unit_mask),
  .out_valid    (out_valid),
  .out_hit      (out_hit),
  .out_cause    (out_cause),
  .out_flags    (out_flags)
);

// File: tb/tb_exc_cause_sel.sv
`timescale 1ns/1ps
module tb_exc_cause_sel;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_mode;
  logic [15:0] in_flags;
  logic [15:0] in_unit_mask;
  logic        out_valid;
  logic        out_hit;
  logic [3:0]  out_cause;
  logic [15:0] out_flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  exc_cause_sel dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_flags(in_flags), .in_unit_mask(in_unit_mask),
    .out_valid(out_valid), .out_hit(out_hit), .out_cause(out_cause),
    .out_flags(out_flags)
  );

  int prio [14] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5};

  function automatic logic [15:0] model_mask(logic [15:0] f, logic [1:0] m, logic [15:0] u);
    logic [15:0] r;
    r = f;
    r[10] = 1'b0;                    // R3
    r[14] = 1'b0;
    if (m[0]) r = r & 16'h1007;      // R5, R7
    if (m[1]) r = r & u;             // R6, R7
    return r;
  endfunction

  function automatic logic [3:0] model_pick(logic [15:0] v);
    for (int k = 0; k < 14; k++)
      if (v[prio[k]]) return 4'(prio[k]);   // R8
    return 4'd0;                            // R9
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(string req, logic v, logic [1:0] m, logic [15:0] f, logic [15:0] u);
    logic [15:0] em;
    @(negedge clk);
    in_valid = v; in_mode = m; in_flags = f; in_unit_mask = u;
    @(posedge clk);
    #1;
    em = v ? model_mask(f, m, u) : 16'h0;
    check(req, "valid", 32'(out_valid), 32'(v));
    check(req, "flags", 32'(out_flags), 32'(em));
    check(req, "hit",   32'(out_hit),   32'(em != 16'h0));
    check(req, "cause", 32'(out_cause), 32'(model_pick(em)));
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b1; in_mode = 2'b00; in_flags = 16'hFFFF; in_unit_mask = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "valid", 32'(out_valid), 0);
    check("R1", "hit",   32'(out_hit), 0);
    check("R1", "cause", 32'(out_cause), 0);
    check("R1", "flags", 32'(out_flags), 0);
    @(negedge clk);
    rst = 1'b0;

    // R8: adjacent-rank pairs, winner must be the higher-ranked one
    for (int k = 0; k < 13; k++)
      apply("R8", 1'b1, 2'b00, (16'h1 << prio[k]) | (16'h1 << prio[k+1]), 16'h0);
    // R8: each cause alone
    for (int k = 0; k < 14; k++)
      apply("R8", 1'b1, 2'b00, 16'h1 << prio[k], 16'h0);
    // R4, R5, R6, R7 with all flags set
    apply("R4", 1'b1, 2'b00, 16'hFFFF, 16'h0000);
    apply("R5", 1'b1, 2'b01, 16'hFFFF, 16'h0000);
    apply("R6", 1'b1, 2'b10, 16'hFFFF, 16'h00F0);
    apply("R7", 1'b1, 2'b11, 16'hFFFF, 16'h1004);
    // R3: only unimplemented bits
    apply("R3", 1'b1, 2'b00, 16'h4400, 16'h0);
    apply("R3", 1'b1, 2'b10, 16'h4400, 16'hFFFF);
    // R9: nothing survives
    apply("R9", 1'b1, 2'b00, 16'h0000, 16'h0);
    apply("R9", 1'b1, 2'b01, 16'hEFF8, 16'h0);
    apply("R9", 1'b1, 2'b10, 16'hFFFF, 16'h0000);
    // R2: idle cycle clears outputs
    apply("R2", 1'b0, 2'b00, 16'hFFFF, 16'hFFFF);
    apply("R2", 1'b1, 2'b00, 16'h0020, 16'h0);
    // R10 and mix: random
    for (int i = 0; i < 400; i++)
      apply("R10", ($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
            16'($urandom()), 16'($urandom()));
    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_flags = 16'h0008;
    @(posedge clk); #1;
    check("R1", "valid after reset", 32'(out_valid), 0);
    check("R1", "flags after reset", 32'(out_flags), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule